// File: doc/BRIEF.md
# Asynchronous Read Handshake Engine

This block carries a single-word read across a clockless link that shares one set of lines between address and data. Two sides sit on the link. The requesting side takes a read command with an address and hands back the word that was read. The responding side sits in front of a small register-array memory. Three control wires coordinate them: a request, a data-valid and a shared acknowledge. The acknowledge answers the request on one step and answers the data-valid on a later step.

Each side is a synchronous state machine in its own clock domain, and the two clocks need not be related. A side looks at the other side's control wires only after a two-flop synchronizer. Each edge of each wire is one step of a four-phase exchange. For each read, the requester raises request and drives the address. The responder captures the address and raises acknowledge. The requester then drops request and stops driving, and the responder lowers acknowledge. The responder raises data-valid and drives the word. The requester captures the word and raises acknowledge. Finally the responder drops data-valid and stops driving, and the requester lowers acknowledge.

The shared lines are modelled as a multiplexer with one drive-enable per side. The acknowledge wire is the OR of the two sides' acknowledge outputs. The memory is filled through a write port in the responder's clock domain.

Top module: `rdhs_engine`

## Requirements
- R1: During and after reset, request, data-valid, acknowledge, both drive-enables, `busy` and `done` are all 0.
- R2: The requester drives the shared lines, carrying the command address in the low `ADDR_W` bits, on every cycle that request is high. Request and data-valid are never high together.
- R3: The responder raises data-valid only while acknowledge is low. While data-valid is high, the responder drives the shared lines with the memory word at the captured address.
- R4: A command is taken only when the requester is idle, meaning `busy` is 0, which implies acknowledge has returned low. A `cmd_valid` given while `busy` is 1 produces no transfer and no `done`. Request rises only while acknowledge is low.
- R5: The two drive-enables (`m_drive`, `s_drive`) are never 1 together.
- R6: Each accepted command produces exactly one `done` pulse one `clk_m` cycle wide. `done_data` holds the memory word at the command address.
- R7: A write through `ld_en`/`ld_addr`/`ld_data` on `clk_s` stores the word at that address. A later read of that address returns the stored word.
- R8: Every memory word is 0 after reset.
- R9: Reads issued back to back, in ascending and in descending address order, each return the word at their own address, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Requester clock |
| rst_m_n | input | 1 | Requester reset, active low, asynchronous |
| cmd_valid | input | 1 | Read command strobe |
| cmd_addr | input | ADDR_W | Read command address |
| busy | output | 1 | Requester is in a transaction or waiting for acknowledge to drop |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | DATA_W | Word returned by the completed read |
| clk_s | input | 1 | Responder clock |
| rst_s_n | input | 1 | Responder reset, active low, asynchronous |
| ld_en | input | 1 | Memory write strobe |
| ld_addr | input | ADDR_W | Memory write address |
| ld_data | input | DATA_W | Memory write word |
| line_req | output | 1 | Request wire of the link |
| line_rdy | output | 1 | Data-valid wire of the link |
| line_ack | output | 1 | Shared acknowledge wire |
| line_bus | output | BUS_W | Shared address/data lines |
| m_drive | output | 1 | Requester drive-enable on the shared lines |
| s_drive | output | 1 | Responder drive-enable on the shared lines |

## Verification
The hardest case to reach from the ports is a command that arrives while the requester is still busy with the previous read, in particular during the tail of a transfer when acknowledge is still high. The bench issues a read and then pulses `cmd_valid` with another address for several cycles while `busy` is still high. The scoreboard then flags any `done` that has no queued expectation. The two clocks run at unrelated periods. On every edge of both clocks, the bench monitors the drive-enables, the request/data-valid pair and the level of acknowledge at each rising data-valid.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;
    typedef enum logic [2:0] {
        M_IDLE,
        M_REQ,
        M_REL,
        M_WAIT,
        M_HOLD,
        M_DRAIN
    } mst_state_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACK,
        S_GAP,
        S_DATA,
        S_END
    } slv_state_e;
endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rdhs_master.sv
module rdhs_master
    import rdhs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int BUS_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              ack_in,
    input  logic              rdy_in,
    input  logic [DATA_W-1:0] bus_in,
    output logic              req_o,
    output logic              ack_o,
    output logic              oe_o,
    output logic [BUS_W-1:0]  dat_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] done_data_o
);
    typedef struct packed {
        mst_state_e        st;
        logic              req;
        logic              ack;
        logic              oe;
        logic [BUS_W-1:0]  dat;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } mst_regs_t;

    mst_regs_t r_d, r_q;
    logic      ack_s, rdy_s;

    rdhs_sync #(.STAGES(SYNC_N)) u_sync_ack (.clk(clk), .rst_n(rst_n), .d(ack_in), .q(ack_s));
    rdhs_sync #(.STAGES(SYNC_N)) u_sync_rdy (.clk(clk), .rst_n(rst_n), .d(rdy_in), .q(rdy_s));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            M_IDLE: begin
                if (cmd_valid && !ack_s) begin
                    r_d.req = 1'b1;
                    r_d.oe  = 1'b1;
                    r_d.dat = BUS_W'(cmd_addr);
                    r_d.st  = M_REQ;
                end
            end
            M_REQ: begin
                if (ack_s) begin
                    r_d.req = 1'b0;
                    r_d.oe  = 1'b0;
                    r_d.st  = M_REL;
                end
            end
            M_REL: begin
                if (!ack_s) r_d.st = M_WAIT;
            end
            M_WAIT: begin
                if (rdy_s) begin
                    r_d.rdata = bus_in;
                    r_d.ack   = 1'b1;
                    r_d.st    = M_HOLD;
                end
            end
            M_HOLD: begin
                if (!rdy_s) begin
                    r_d.ack  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.st   = M_DRAIN;
                end
            end
            M_DRAIN: begin
                if (!ack_s) r_d.st = M_IDLE;
            end
            default: r_d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: M_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_o       = r_q.req;
    assign ack_o       = r_q.ack;
    assign oe_o        = r_q.oe;
    assign dat_o       = r_q.dat;
    assign busy_o      = (r_q.st != M_IDLE);
    assign done_o      = r_q.done;
    assign done_data_o = r_q.rdata;
endmodule

// File: rtl/rdhs_slave.sv
module rdhs_slave
    import rdhs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int BUS_W  = 8,
    parameter int SYNC_N = 2,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              req_in,
    input  logic              ack_in,
    input  logic [ADDR_W-1:0] bus_in,
    output logic              ack_o,
    output logic              rdy_o,
    output logic              oe_o,
    output logic [BUS_W-1:0]  dat_o
);
    typedef struct packed {
        slv_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              ack;
        logic              rdy;
        logic              oe;
        logic [BUS_W-1:0]  dat;
    } slv_regs_t;

    slv_regs_t         r_d, r_q;
    logic              req_s, ack_s;
    logic [DATA_W-1:0] mem_q [DEPTH];

    rdhs_sync #(.STAGES(SYNC_N)) u_sync_req (.clk(clk), .rst_n(rst_n), .d(req_in), .q(req_s));
    rdhs_sync #(.STAGES(SYNC_N)) u_sync_ack (.clk(clk), .rst_n(rst_n), .d(ack_in), .q(ack_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (ld_en) begin
            mem_q[ld_addr] <= ld_data;
        end
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: begin
                if (req_s) begin
                    r_d.addr = bus_in;
                    r_d.ack  = 1'b1;
                    r_d.st   = S_ACK;
                end
            end
            S_ACK: begin
                if (!req_s) begin
                    r_d.ack = 1'b0;
                    r_d.st  = S_GAP;
                end
            end
            S_GAP: begin
                if (!ack_s) begin
                    r_d.rdy = 1'b1;
                    r_d.oe  = 1'b1;
                    r_d.dat = BUS_W'(mem_q[r_q.addr]);
                    r_d.st  = S_DATA;
                end
            end
            S_DATA: begin
                if (ack_s) begin
                    r_d.rdy = 1'b0;
                    r_d.oe  = 1'b0;
                    r_d.st  = S_END;
                end
            end
            S_END: begin
                if (!ack_s) r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_o = r_q.ack;
    assign rdy_o = r_q.rdy;
    assign oe_o  = r_q.oe;
    assign dat_o = r_q.dat;
endmodule

// File: rtl/rdhs_engine.sv
module rdhs_engine #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2,
    localparam int BUS_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic              clk_m,
    input  logic              rst_m_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    input  logic              clk_s,
    input  logic              rst_s_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic              line_req,
    output logic              line_rdy,
    output logic              line_ack,
    output logic [BUS_W-1:0]  line_bus,
    output logic              m_drive,
    output logic              s_drive
);
    logic             ack_m, ack_s;
    logic [BUS_W-1:0] dat_m, dat_s;

    // Shared lines: each side enables its own driver; acknowledge is wired-OR.
    assign line_ack = ack_m | ack_s;
    assign line_bus = m_drive ? dat_m : (s_drive ? dat_s : '0);

    rdhs_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .SYNC_N(SYNC_N)
    ) u_master (
        .clk(clk_m), .rst_n(rst_m_n),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .ack_in(line_ack), .rdy_in(line_rdy), .bus_in(line_bus[DATA_W-1:0]),
        .req_o(line_req), .ack_o(ack_m), .oe_o(m_drive), .dat_o(dat_m),
        .busy_o(busy), .done_o(done), .done_data_o(done_data)
    );

    rdhs_slave #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .SYNC_N(SYNC_N)
    ) u_slave (
        .clk(clk_s), .rst_n(rst_s_n),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .req_in(line_req), .ack_in(line_ack), .bus_in(line_bus[ADDR_W-1:0]),
        .ack_o(ack_s), .rdy_o(line_rdy), .oe_o(s_drive), .dat_o(dat_s)
    );
endmodule

// File: rtl/rdhs_chk.sv
module rdhs_chk (
    input logic clk_m,
    input logic rst_m_n,
    input logic clk_s,
    input logic rst_s_n,
    input logic line_req,
    input logic line_rdy,
    input logic line_ack,
    input logic m_drive,
    input logic s_drive,
    input logic done
);
    // R5
    no_collide_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n || !rst_s_n)
        !(m_drive && s_drive));

    // R2
    req_rdy_excl_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n || !rst_s_n)
        !(line_req && line_rdy));

    // R6
    done_pulse_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n)
        done |=> !done);

    // R4
    req_rise_ack_low_chk: assert property (@(posedge clk_m) disable iff (!rst_m_n || !rst_s_n)
        $rose(line_req) |-> !line_ack);

    // R3
    rdy_rise_ack_low_chk: assert property (@(posedge clk_s) disable iff (!rst_m_n || !rst_s_n)
        $rose(line_rdy) |-> !line_ack);
endmodule

bind rdhs_engine rdhs_chk u_chk (
    .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
    .line_req(line_req), .line_rdy(line_rdy), .line_ack(line_ack),
    .m_drive(m_drive), .s_drive(s_drive), .done(done)
);

// File: tb/rdhs_engine_bench.sv
`timescale 1ns/1ps
module rdhs_engine_bench;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int BW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk_m = 1'b0, clk_s = 1'b0;
    logic          rst_m_n = 1'b0, rst_s_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          busy, done;
    logic [DW-1:0] done_data;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic          line_req, line_rdy, line_ack, m_drive, s_drive;
    logic [BW-1:0] line_bus;

    always #5 clk_m = ~clk_m;
    always #7 clk_s = ~clk_s;

    rdhs_engine #(.ADDR_W(AW), .DATA_W(DW)) u_rdhs_engine (
        .clk_m(clk_m), .rst_m_n(rst_m_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .busy(busy), .done(done), .done_data(done_data),
        .clk_s(clk_s), .rst_s_n(rst_s_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .line_req(line_req), .line_rdy(line_rdy), .line_ack(line_ack), .line_bus(line_bus),
        .m_drive(m_drive), .s_drive(s_drive)
    );

    int errors = 0;
    int checks = 0;
    int pushed = 0;
    int dones  = 0;
    int viol_r2 = 0, viol_r3 = 0, viol_r5 = 0;
    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] exp_q [$];
    logic [AW-1:0] addr_q [$];
    logic [AW-1:0] cur_addr = '0;
    logic          prev_rdy = 1'b0;
    logic          live = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: issues a read and queues the expected word.
    task automatic issue_read(input logic [AW-1:0] a);
        do @(negedge clk_m); while (busy);
        cmd_valid = 1'b1;
        cmd_addr  = a;
        cur_addr  = a;
        exp_q.push_back(ref_mem[a]);
        addr_q.push_back(a);
        pushed++;
        @(negedge clk_m);
        cmd_valid = 1'b0;
    endtask

    task automatic load_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk_s);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        ref_mem[a] = d;
        @(negedge clk_s);
        ld_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk_m); while (busy || exp_q.size() != 0);
        repeat (4) @(negedge clk_m);
    endtask

    // Monitor: pops the scoreboard at each completion (R6, R9).
    always @(negedge clk_m) begin
        if (live && done) begin
            dones++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 done without accepted command", 1, 0);
            end else begin
                logic [DW-1:0] e;
                logic [AW-1:0] a;
                e = exp_q.pop_front();
                a = addr_q.pop_front();
                check(done_data == e, $sformatf("R6/R9 read data addr %0d", a), done_data, e);
            end
        end
        if (live) begin
            if (line_req && (!m_drive || line_bus[AW-1:0] != cur_addr)) viol_r2++;
            if (line_req && line_rdy) viol_r2++;
            if (m_drive && s_drive) viol_r5++;
        end
    end

    always @(negedge clk_s) begin
        if (live) begin
            if (line_rdy && (!s_drive || m_drive || line_bus[DW-1:0] != ref_mem[cur_addr])) viol_r3++;
            if (line_rdy && !prev_rdy && line_ack) viol_r3++;
            if (m_drive && s_drive) viol_r5++;
        end
        prev_rdy = line_rdy;
    end

    initial begin
        repeat (100000) @(posedge clk_m);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (5) @(negedge clk_s);
        // R1: reset state
        check(line_req == 0, "R1 req in reset", line_req, 0);
        check(line_rdy == 0 && line_ack == 0, "R1 rdy/ack in reset", {line_rdy, line_ack}, 0);
        check(m_drive == 0 && s_drive == 0, "R1 drivers in reset", {m_drive, s_drive}, 0);
        check(busy == 0 && done == 0, "R1 busy/done in reset", {busy, done}, 0);
        rst_m_n = 1'b1;
        rst_s_n = 1'b1;
        live = 1'b1;
        repeat (3) @(negedge clk_m);
        check(line_req == 0 && line_ack == 0 && busy == 0, "R1 idle after reset",
              {line_req, line_ack, busy}, 0);

        // R8: memory is zero after reset
        issue_read(4'd5);
        wait_idle();
        issue_read(4'd12);
        wait_idle();

        // R7: fill the memory
        for (int i = 0; i < DEPTH; i++) load_word(AW'(i), DW'((i * 37 + 11) & 8'hFF));

        // R9: ascending then descending back-to-back reads
        for (int i = 0; i < DEPTH; i++) issue_read(AW'(i));
        wait_idle();
        for (int i = DEPTH - 1; i >= 0; i--) issue_read(AW'(i));
        wait_idle();

        // R4: commands while busy are ignored
        issue_read(4'd2);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk_m);
            cmd_valid = busy;
            cmd_addr  = 4'd9;
        end
        cmd_valid = 1'b0;
        wait_idle();
        check(dones == pushed, "R4 one done per accepted command", dones, pushed);

        // R7: overwrite one word and read it back
        load_word(4'd7, 8'hA5);
        issue_read(4'd7);
        wait_idle();
        load_word(4'd0, 8'h3C);
        issue_read(4'd0);
        issue_read(4'd15);
        wait_idle();

        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        check(dones == pushed, "R6 done count", dones, pushed);
        check(viol_r2 == 0, "R2 request/address discipline", viol_r2, 0);
        check(viol_r3 == 0, "R3 data-valid discipline", viol_r3, 0);
        check(viol_r5 == 0, "R5 driver overlap", viol_r5, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule